// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `W` bits (4 by default) one multiplier bit at a time. A start pulse in the idle state latches the multiplicand into a hold register. The same pulse loads the multiplier into the low section of a working register. That register is a chain of 2W+1 bits: a carry bit, an accumulator of W bits, and the W-bit multiplier section. The least significant bit of the low section decides whether a step adds.

For each of the W iterations the control spends two cycles. In the add cycle, if the low section's LSB is 1, a carry-lookahead adder result is written into the carry bit and the accumulator. The adder sums the accumulator and the multiplicand. In the shift cycle the whole chain moves right by one place, and a zero enters at the top. Each bit of the chain only ever holds, loads from the adder, or shifts right. After the last shift the block pulses `done` for one cycle. The 2W-bit product on `product` is the accumulator followed by the low section, and it stays there until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: One cycle after `done` is high, `product` equals the unsigned product of `mcand` and `mplier` as sampled on the accepting edge, for every operand pair. This includes results whose additions carry out of the accumulator, such as 15 x 15 = 225.
- R2: `done` is high for exactly one cycle. It goes high 2W clock edges after the edge that accepted `start` (8 edges for W = 4).
- R3: `busy` is high from the cycle after an accepted start until the cycle before `done`. `busy` and `done` are never high together.
- R4: A `start` pulse while `busy` or `done` is high is ignored. The running result, the `done` timing and the latched operands are unchanged.
- R5: While the block is idle and `start` is low, `product` holds its last value.
- R6: After reset `busy` = 0, `done` = 0 and `product` = 0.
- R7: The adder computes the carries in two-level carry-lookahead form from generate and propagate terms, not by rippling. Its carry-out and sum equal the arithmetic sum of accumulator and multiplicand.
- R8: Changes on `mcand` and `mplier` after the accepting edge do not affect the result.
- R9: A multiplier bit of 0 skips the add. A zero multiplier or a zero multiplicand gives product 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Accumulator and low section, unsigned product |

## Verification
The iterations compound an error, so any wrong internal state shows up at the ports. A mis-timed shift or a dropped carry bit corrupts `product` for some operand pairs when `done` is seen, about 2W cycles after start. A wrong iteration count moves the `done` edge off its 2W-edge slot, or leaves the product scaled by a power of two. Running all operand pairs exposes any adder or carry fault. Restart attempts mid-run expose a control path that re-accepts `start`, because the result or the `done` timing changes.

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ADD, S_SHIFT, S_FIN} st_t;
  st_t state;

  logic          cy;
  logic [W-1:0]  acc, lo, mc;
  logic [CW-1:0] cnt;

  logic [W-1:0] g, p, s;
  logic [W:0]   c;

  assign g = acc & mc;
  assign p = acc ^ mc;
  assign s = p ^ c[W-1:0];

  always_comb begin
    logic t;
    c = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = -1; j <= i; j++) begin
        t = (j < 0) ? 1'b0 : g[j];
        for (int k = j + 1; k <= i; k++) t = t & p[k];
        c[i+1] = c[i+1] | t;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cy    <= 1'b0;
      acc   <= '0;
      lo    <= '0;
      mc    <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cy    <= 1'b0;
          acc   <= '0;
          lo    <= mplier;
          mc    <= mcand;
          cnt   <= '0;
          state <= S_ADD;
        end
        S_ADD: begin
          if (lo[0]) {cy, acc} <= {c[W], s};
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          {cy, acc, lo} <= {1'b0, cy, acc, lo[W-1:1]};
          cnt   <= cnt + 1'b1;
          state <= (cnt == CW'(W - 1)) ? S_FIN : S_ADD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state == S_ADD) || (state == S_SHIFT);
  assign done    = (state == S_FIN);
  assign product = {acc, lo};

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r4_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> $stable(mc));

  a_r5_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> $stable(product));

  a_r7_cla_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADD) |-> ({c[W], s} == ({1'b0, acc} + {1'b0, mc})));

  a_r9_shift_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT) |=> !cy);
endmodule

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*W-1:0] product;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shift_add_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product));

  localparam logic [15:0] VEC [10] = '{
    {4'd3, 4'd4, 8'd12}, {4'd7, 4'd9, 8'd63}, {4'd13, 4'd8, 8'd104},
    {4'd15, 4'd15, 8'd225}, {4'd0, 4'd9, 8'd0}, {4'd11, 4'd0, 8'd0},
    {4'd1, 4'd1, 8'd1}, {4'd15, 4'd1, 8'd15}, {4'd8, 4'd8, 8'd64},
    {4'd10, 4'd5, 8'd50}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input bit poke, output int lat, output int res);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = ~b;
    lat = 0;
    while (!done && lat < 40) begin
      if (poke && lat == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    res = int'(product);
  endtask

  initial begin
    int lat, res;
    repeat (3) @(negedge clk);
    chk("R6 busy", int'(busy), 0);
    chk("R6 done", int'(done), 0);
    chk("R6 product", int'(product), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      run(VEC[i][15:12], VEC[i][11:8], 1'b0, lat, res);
      chk("R1 R7 R9 table product", res, int'(VEC[i][7:0]));
      chk("R2 latency", lat, 2 * W);
    end

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run(W'(a), W'(b), 1'b0, lat, res);
        chk("R1 R8 exhaustive", res, a * b);
      end

    @(negedge clk);
    mcand = 4'd6; mplier = 4'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", int'(busy), 1);
    chk("R3 no done at start", int'(done), 0);
    repeat (2 * W - 1) @(negedge clk);
    chk("R3 busy before done", int'(busy), 1);
    @(negedge clk);
    chk("R2 done pulse", int'(done), 1);
    chk("R3 busy low at done", int'(busy), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done single", int'(done), 0);
    chk("R4 start at done ignored", int'(busy), 0);
    chk("R4 product after start at done", int'(product), 42);
    repeat (5) @(negedge clk);
    chk("R5 product held", int'(product), 42);

    run(4'd9, 4'd11, 1'b1, lat, res);
    chk("R4 restart ignored product", res, 99);
    chk("R4 restart ignored latency", lat, 2 * W);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R6 product after reset", int'(product), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule